// File: doc/BRIEF.md
# Ethernet Frame Size Statistics Counters

This block collects frame statistics for an Ethernet MAC. When a frame ends, the transmitter and the receiver each pulse an end-of-frame strobe. The strobe carries the frame length in octets. The receive strobe also carries the destination address and a flag that says whether the MAC judged the frame error-free. A transmit event and a receive event may arrive in the same cycle.

From these events the block keeps eleven saturating counters, each as wide as `CNT_W`:
- three receive-side counters, for good frames, good broadcast frames and good multicast frames;
- two octet totals, one for transmitted octets and one for all octets on the network;
- six frame-size buckets shared by both directions.

The largest bucket is bounded by a programmable maximum length. Software reads a counter by placing its index on a plain register port; the read data is combinational. To clear a counter, software writes back the value it read. The write subtracts that value, so events that land between the read and the write are kept.

The event strobes carry no back-pressure. The block accepts one transmit and one receive event in every cycle, so an upstream MAC never waits. The register port is a plain control port.

Top module: `frame_stats_top`

## Requirements
- R1: While `rst_n` is low, every counter clears to zero. After reset, every index reads back 0.
- R2: The good-frame counter (index 0) increments once for each receive event with `rx_good`=1. A receive event with `rx_good`=0 leaves it unchanged, and so does any cycle with `rx_valid`=0.
- R3: The broadcast counter (index 1) increments for a good receive event whose `rx_dst` is all ones.
- R4: The multicast counter (index 2) increments for a good receive event where bit 40 of `rx_dst` is set and the address is not all ones. Bit 40 is the LSB of the first destination byte, `rx_dst[47:40]`. A frame with bit 40 clear moves neither index 1 nor index 2.
- R5: Size buckets sit at indices 5 to 9, and each covers a fixed length range. Index 5 is exactly 64 octets, index 6 is 65–127, index 7 is 128–255, index 8 is 256–511 and index 9 is 512–1023. Any valid frame whose length falls in a range adds one, whether it is transmitted or received and whether or not `rx_good` is set.
- R6: Index 10 counts frames from 1024 up to and including `max_len`. A frame shorter than 64 or longer than `max_len` touches no bucket. A bucket whose lower bound lies above `max_len` never counts.
- R7: A transmit event and a receive event may fall in the same bucket in the same cycle. That bucket then grows by 2.
- R8: Index 3 adds `tx_len` for every transmit event. Index 4 adds the length of every transmit event and every receive event, including receive events with `rx_good`=0.
- R9: A counter that would pass 0xFFFFFFFF holds at 0xFFFFFFFF instead of wrapping.
- R10: A write with `reg_wr`=1 to index 0–10 works in three steps. It first adds that cycle's increment, then subtracts `reg_wdata`, and the result never goes below zero. Writes to indices 11–15 change nothing.
- R11: `reg_rdata` shows the addressed counter in the same cycle. It reads 0 for indices 11–15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| max_len | input | LEN_W | Largest frame length counted by the top bucket |
| tx_valid | input | 1 | Transmit end-of-frame strobe |
| tx_len | input | LEN_W | Transmitted frame length in octets |
| rx_valid | input | 1 | Receive end-of-frame strobe |
| rx_len | input | LEN_W | Received frame length in octets |
| rx_good | input | 1 | Received frame is free of errors |
| rx_dst | input | MAC_W | Destination address; bits 47:40 are the first byte |
| reg_addr | input | ADDR_W | Counter index for reads and writes |
| reg_wr | input | 1 | Write strobe: subtract `reg_wdata` from the addressed counter |
| reg_wdata | input | CNT_W | Value to subtract |
| reg_rdata | output | CNT_W | Addressed counter value |

## Verification
The bench probes the length edges on each side of every bucket boundary, including 63, 1518 and 1519, and moves `max_len` below 1024. A design with an off-by-one range would count a frame one bucket too high or too low. Same-bucket transmit and receive pairs expose a bucket that adds 1 instead of 2. Multicast addresses with other first-byte bits set and a broadcast frame flagged bad would catch a design that tests the wrong address bit or counts errored frames. Subtracting more than the current value, subtracting in the same cycle as an increment, and driving the network total past its top would catch a design that wraps to huge values or drops the event that coincides with the clear.

// File: rtl/frame_stats_pkg.sv
package frame_stats_pkg;
  // counter index map used by the register port
  localparam int NUM_BKT   = 6;
  localparam int IDX_GOOD  = 0;
  localparam int IDX_BCAST = 1;
  localparam int IDX_MCAST = 2;
  localparam int IDX_TXOCT = 3;
  localparam int IDX_NETOC = 4;
  localparam int IDX_BKT0  = 5;
  localparam int NUM_CNT   = IDX_BKT0 + NUM_BKT;
endpackage

// File: rtl/stat_size_bucket.sv
module stat_size_bucket #(
  parameter int LEN_W = 16,
  parameter int NUM_B = 6
) (
  input  logic             valid,
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] max_len,
  output logic [NUM_B-1:0] hit
);
  // bucket 0: exactly 64; bucket k: (32<<k)(+1 for k==1) .. (64<<k)-1; last: open top bounded by max_len
  for (genvar k = 0; k < NUM_B; k++) begin : g_bkt
    localparam int LO_I = (k == 0) ? 64 : ((32 << k) + ((k == 1) ? 1 : 0));
    localparam int HI_I = (k == 0) ? 64 : ((64 << k) - 1);
    localparam logic [LEN_W-1:0] LO = LEN_W'(LO_I);
    localparam logic [LEN_W-1:0] HI = LEN_W'(HI_I);
    logic in_lo, in_max, in_hi;
    assign in_lo  = (len >= LO);
    assign in_max = (len <= max_len);
    if (k == NUM_B - 1) begin : g_top
      assign in_hi = 1'b1;
    end else begin : g_mid
      assign in_hi = (len <= HI);
    end
    assign hit[k] = valid & in_lo & in_hi & in_max;
  end
endmodule

// File: rtl/stat_sat_cnt.sv
module stat_sat_cnt #(
  parameter int W     = 32,
  parameter int INC_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc,
  input  logic             sub_en,
  input  logic [W-1:0]     sub_val,
  output logic [W-1:0]     q
);
  localparam int EW = W + 2;
  localparam logic [EW-1:0] TOP = {2'b00, {W{1'b1}}};

  logic [EW-1:0] sum, sub_x, diff, nxt;

  always_comb begin
    sum   = {2'b00, q} + EW'(inc);
    sub_x = sub_en ? {2'b00, sub_val} : '0;
    diff  = (sum < sub_x) ? '0 : (sum - sub_x);
    nxt   = (diff > TOP) ? TOP : diff;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt[W-1:0];
  end
endmodule

// File: rtl/frame_stats_top.sv
module frame_stats_top
  import frame_stats_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 32,
  parameter int MAC_W  = 48,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  max_len,
  input  logic              tx_valid,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic              rx_valid,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic              rx_good,
  input  logic [MAC_W-1:0]  rx_dst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata
);
  localparam int INC_W   = LEN_W + 1;
  localparam int GRP_BIT = MAC_W - 8;

  logic [NUM_BKT-1:0] tx_hit, rx_hit;
  logic rx_ok, rx_bc, rx_mc;
  logic [NUM_CNT-1:0][INC_W-1:0] inc;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;

  stat_size_bucket #(.LEN_W(LEN_W), .NUM_B(NUM_BKT)) u_tx_bkt (
    .valid(tx_valid), .len(tx_len), .max_len(max_len), .hit(tx_hit)
  );
  stat_size_bucket #(.LEN_W(LEN_W), .NUM_B(NUM_BKT)) u_rx_bkt (
    .valid(rx_valid), .len(rx_len), .max_len(max_len), .hit(rx_hit)
  );

  // address class of good received frames
  assign rx_ok = rx_valid & rx_good;
  assign rx_bc = rx_ok & (&rx_dst);
  assign rx_mc = rx_ok & rx_dst[GRP_BIT] & ~(&rx_dst);

  always_comb begin
    logic [INC_W-1:0] tx_part, rx_part;
    tx_part = tx_valid ? INC_W'(tx_len) : '0;
    rx_part = rx_valid ? INC_W'(rx_len) : '0;
    inc            = '0;
    inc[IDX_GOOD]  = INC_W'(rx_ok);
    inc[IDX_BCAST] = INC_W'(rx_bc);
    inc[IDX_MCAST] = INC_W'(rx_mc);
    inc[IDX_TXOCT] = tx_part;
    inc[IDX_NETOC] = tx_part + rx_part;
    for (int k = 0; k < NUM_BKT; k++)
      inc[IDX_BKT0+k] = INC_W'(tx_hit[k]) + INC_W'(rx_hit[k]);
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic sel;
    assign sel = reg_wr && (reg_addr == ADDR_W'(i));
    stat_sat_cnt #(.W(CNT_W), .INC_W(INC_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc[i]),
      .sub_en(sel), .sub_val(reg_wdata), .q(cnt_q[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (reg_addr == ADDR_W'(i)) reg_rdata = cnt_q[i];
  end
endmodule

// File: rtl/frame_stats_chk.sv
module frame_stats_chk
  import frame_stats_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          tx_valid,
  input logic                          rx_valid,
  input logic                          reg_wr,
  input logic [NUM_BKT-1:0]            tx_hit,
  input logic [NUM_BKT-1:0]            rx_hit,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  // R5 and R6: a frame lands in at most one bucket
  assert_tx_one_bucket_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_hit));
  assert_rx_one_bucket_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_hit));

  // R10: with no event and no write, nothing moves
  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && !rx_valid && !reg_wr) |=> $stable(cnt_q));

  // R2: the good counter moves only on receive events or writes
  assert_good_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !reg_wr) |=> (cnt_q[IDX_GOOD] == $past(cnt_q[IDX_GOOD])));

  // R9: network total never falls without a write, and holds at the top
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> (cnt_q[IDX_NETOC] >= $past(cnt_q[IDX_NETOC])));
  assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q[IDX_NETOC] == TOP && !reg_wr) |=> (cnt_q[IDX_NETOC] == TOP));
endmodule

bind frame_stats_top frame_stats_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .rx_valid(rx_valid),
  .reg_wr(reg_wr), .tx_hit(tx_hit), .rx_hit(rx_hit), .cnt_q(cnt_q)
);

// File: tb/tb_frame_stats_top.sv
module tb_frame_stats_top;
  localparam int NC = 11;
  localparam int NV = 12;
  localparam logic [31:0] TOP = 32'hFFFF_FFFF;

  typedef struct packed {
    logic        tv;
    logic [15:0] tl;
    logic        rv;
    logic [15:0] rl;
    logic        rg;
    logic [47:0] dst;
    logic [2:0]  tb;   // expected tx bucket, 7 = none
    logic [2:0]  rb;   // expected rx bucket, 7 = none
    logic        eg, eb, em;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'd64,   1'b0, 16'd0,    1'b0, 48'h0,            3'd0, 3'd7, 1'b0, 1'b0, 1'b0},
    '{1'b0, 16'd0,    1'b1, 16'd64,   1'b1, 48'h001122334455, 3'd7, 3'd0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 16'd65,   1'b1, 16'd127,  1'b1, 48'hFFFFFFFFFFFF, 3'd1, 3'd1, 1'b1, 1'b1, 1'b0},
    '{1'b1, 16'd127,  1'b1, 16'd128,  1'b1, 48'h01005E000001, 3'd1, 3'd2, 1'b1, 1'b0, 1'b1},
    '{1'b0, 16'd0,    1'b1, 16'd255,  1'b1, 48'h03FFFFFFFFFF, 3'd7, 3'd2, 1'b1, 1'b0, 1'b1},
    '{1'b1, 16'd256,  1'b1, 16'd511,  1'b0, 48'hFFFFFFFFFFFF, 3'd3, 3'd3, 1'b0, 1'b0, 1'b0},
    '{1'b1, 16'd512,  1'b1, 16'd1023, 1'b1, 48'hFE0000000000, 3'd4, 3'd4, 1'b1, 1'b0, 1'b0},
    '{1'b1, 16'd1024, 1'b1, 16'd1518, 1'b1, 48'h020000000001, 3'd5, 3'd5, 1'b1, 1'b0, 1'b0},
    '{1'b1, 16'd63,   1'b1, 16'd1519, 1'b0, 48'hFFFFFFFFFFFF, 3'd7, 3'd7, 1'b0, 1'b0, 1'b0},
    '{1'b0, 16'd64,   1'b0, 16'd64,   1'b1, 48'hFFFFFFFFFFFF, 3'd7, 3'd7, 1'b0, 1'b0, 1'b0},
    '{1'b1, 16'd1500, 1'b1, 16'd1500, 1'b1, 48'h0B0000000000, 3'd5, 3'd5, 1'b1, 1'b0, 1'b1},
    '{1'b0, 16'd0,    1'b1, 16'd40,   1'b1, 48'h000000000000, 3'd7, 3'd7, 1'b1, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] max_len = 16'd1518;
  logic        tx_valid = 1'b0, rx_valid = 1'b0, rx_good = 1'b0, reg_wr = 1'b0;
  logic [15:0] tx_len = '0, rx_len = '0;
  logic [47:0] rx_dst = '0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_c [NC];

  always #10 clk = ~clk;

  frame_stats_top dut (
    .clk(clk), .rst_n(rst_n), .max_len(max_len),
    .tx_valid(tx_valid), .tx_len(tx_len),
    .rx_valid(rx_valid), .rx_len(rx_len), .rx_good(rx_good), .rx_dst(rx_dst),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input logic [3:0] a, input logic [31:0] e, input string req);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== e) begin
      fails++;
      $display("FAIL %s index %0d: got %0h expected %0h", req, a, reg_rdata, e);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < NC; i++) check(4'(i), exp_c[i], req);
  endtask

  task automatic apply(input logic tv, input logic [15:0] tl, input logic rv,
                       input logic [15:0] rl, input logic rg, input logic [47:0] d);
    @(negedge clk);
    tx_valid = tv; tx_len = tl; rx_valid = rv; rx_len = rl; rx_good = rg; rx_dst = d;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [31:0] subf(input logic [31:0] a, input logic [31:0] b);
    return (a < b) ? 32'd0 : a - b;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NC; i++) exp_c[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R11 unmapped read
    check_all("R1");
    check(4'd13, 32'd0, "R11");

    // table walk: R2..R8
    for (int v = 0; v < NV; v++) begin
      apply(VECS[v].tv, VECS[v].tl, VECS[v].rv, VECS[v].rl, VECS[v].rg, VECS[v].dst);
      exp_c[0] += 32'(VECS[v].eg);
      exp_c[1] += 32'(VECS[v].eb);
      exp_c[2] += 32'(VECS[v].em);
      if (VECS[v].tv) begin
        exp_c[3] += 32'(VECS[v].tl);
        exp_c[4] += 32'(VECS[v].tl);
      end
      if (VECS[v].rv) exp_c[4] += 32'(VECS[v].rl);
      if (VECS[v].tb != 3'd7) exp_c[5 + int'(VECS[v].tb)] += 1;
      if (VECS[v].rb != 3'd7) exp_c[5 + int'(VECS[v].rb)] += 1;
      check_all("R2-table R3 R4 R5 R6 R7 R8");
    end

    // R10: partial subtract of top bucket
    wr(4'd10, 32'd3);
    exp_c[10] = subf(exp_c[10], 32'd3);
    check(4'd10, exp_c[10], "R10");
    // R10: oversize subtract floors at zero
    wr(4'd2, 32'd100);
    exp_c[2] = 32'd0;
    check(4'd2, exp_c[2], "R10");
    // R10: subtract while an event hits the same counter
    @(negedge clk);
    reg_addr = 4'd5; reg_wdata = exp_c[5]; reg_wr = 1'b1;
    tx_valid = 1'b1; tx_len = 16'd64;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; tx_valid = 1'b0;
    exp_c[5] = 32'd1;
    exp_c[3] += 32'd64;
    exp_c[4] += 32'd64;
    check_all("R10");
    // R10: write to an unmapped index changes nothing
    wr(4'd12, 32'd5);
    check_all("R10");
    check(4'd15, 32'd0, "R11");

    // R6: lowered max length empties the top bucket
    max_len = 16'd1000;
    apply(1'b0, 16'd0, 1'b1, 16'd1000, 1'b1, 48'h0);
    exp_c[0] += 1; exp_c[4] += 1000; exp_c[9] += 1;
    check_all("R6");
    apply(1'b1, 16'd1024, 1'b1, 16'd1001, 1'b0, 48'h0);
    exp_c[3] += 1024; exp_c[4] += 1024 + 1001;
    check_all("R6");
    max_len = 16'd1518;

    // R9: drive the network total past the top
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NC; i++) exp_c[i] = '0;
    check_all("R1");
    @(negedge clk);
    tx_valid = 1'b1; tx_len = 16'hFFFF; rx_valid = 1'b1; rx_len = 16'hFFFF; rx_good = 1'b0;
    repeat (33000) @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0; rx_valid = 1'b0;
    check(4'd4, TOP, "R9");
    check(4'd3, 32'd2162655000, "R8");
    check(4'd0, 32'd0, "R2");
    wr(4'd4, 32'd1);
    check(4'd4, 32'hFFFF_FFFE, "R9");

    finish_run();
  end
endmodule